// File: doc/BRIEF.md
# Serial Input Signature Register

This block compacts the serial response of a circuit under test into a short signature during built-in self-test. The response arrives one bit per clock. On every enabled clock, the register divides the incoming bit stream by the characteristic polynomial 1 + x + x^3. The feedback is taken from the top stage and XORed into the stages inside the register. After a 7-bit response, the 3-bit register holds the remainder of that stream polynomial. This remainder is the signature of the stream.

A test run goes as follows:
- A synchronous clear empties the register.
- Capture enable is held high while the response bits are shifted in.
- A done pulse latches the signature and compares it with a programmable golden value.
- The pass flag then shows whether the circuit produced the expected signature.

A live match flag compares the running signature with the golden value on every cycle. Because 128 possible streams fold onto only 8 signatures, some faulty streams alias onto the good signature. The block does not try to hide this.

Top module: `sisr_compactor`

## Requirements
- R1: After reset, and one clock after a clear, `sig_o`, `final_o` and `pass_o` are all zero.
- R2: When `clear_i` is high, it wins over `en_i` and `done_i` in the same cycle, and the register goes to zero regardless of `din_i`.
- R3: With `en_i` low and `clear_i` low, `sig_o` keeps its value whatever `din_i` does.
- R4: On an enabled clock, with bit k of `sig_o` being the coefficient of x^k, the next value is `sig_o*x + din_i` reduced modulo x^3 + x + 1. That is: bit0 gets din^bit2, bit1 gets bit0^bit2, and bit2 gets bit1.
- R5: After a clear and 7 enabled clocks, `sig_o` equals the remainder of the stream polynomial modulo x^3 + x + 1, where the first bit shifted in is the coefficient of x^6.
- R6: `match_o` is high exactly when `sig_o` equals `expected_i`, within the same cycle.
- R7: A clock with `done_i` high and `clear_i` low does three things. It copies the value `sig_o` had before that edge into `final_o`. It sets `pass_o` to that value compared with `expected_i`. It keeps both until the next done or clear, even while `en_i` shifts further bits.
- R8: Flipping any single bit of a 7-bit stream always changes the final signature, so `pass_o` is low for that stream.
- R9: A stream that differs from the good one by the pattern 0001011 (the polynomial x^3 + x + 1 itself) gives the same signature, and `pass_o` goes high. This shows aliasing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of signature, result and pass |
| en_i | input | 1 | Capture enable; shifts one response bit per clock |
| din_i | input | 1 | Serial response bit from the circuit under test |
| done_i | input | 1 | Latches the signature and the comparison result |
| expected_i | input | 3 | Golden signature |
| sig_o | output | 3 | Running signature, bit k is the coefficient of x^k |
| match_o | output | 1 | Running signature equals golden value |
| final_o | output | 3 | Signature latched at the last done |
| pass_o | output | 1 | Latched signature equalled golden value at the last done |

## Verification
A wrong stage value or a wrong feedback tap appears on `sig_o` one clock after the enabled edge that caused it. The bench checks every shifted bit against its own polynomial-multiply model, so such a fault is reported on the first bit it affects. The step is invertible, so a corrupted state is never washed out by later bits. The same fault therefore also shows up in the final signature and in `pass_o` one clock after done. Streams with one flipped bit in each position, and a stream that aliases onto the good signature, show that the comparison separates good and faulty responses exactly as the remainder arithmetic predicts.

// File: rtl/sisr_pkg.sv
package sisr_pkg;
    // Width of the signature register.
    parameter int unsigned SIG_W = 3;
    // Feedback coefficients c0..c(W-1); x^W is implied. 1 + x + x^3.
    parameter logic [SIG_W-1:0] SIG_POLY = 3'b011;
endpackage

// File: rtl/sisr_step.sv
module sisr_step #(
    parameter int unsigned W = sisr_pkg::SIG_W,
    parameter logic [W-1:0] POLY = sisr_pkg::SIG_POLY
) (
    input  logic [W-1:0] state_i,
    input  logic         bit_i,
    output logic [W-1:0] next_o
);
    logic fb;

    assign fb = state_i[W-1];
    // Stage 0 always takes the incoming bit plus the feedback (c0 = 1).
    assign next_o[0] = bit_i ^ fb;

    for (genvar k = 1; k < W; k++) begin : g_stage
        if (POLY[k]) begin : g_tap
            assign next_o[k] = state_i[k-1] ^ fb;
        end else begin : g_plain
            assign next_o[k] = state_i[k-1];
        end
    end
endmodule

// File: rtl/sisr_judge.sv
module sisr_judge #(
    parameter int unsigned W = sisr_pkg::SIG_W
) (
    input  logic [W-1:0] got_i,
    input  logic [W-1:0] want_i,
    output logic         equal_o
);
    assign equal_o = (got_i == want_i);
endmodule

// File: rtl/sisr_compactor.sv
module sisr_compactor #(
    parameter int unsigned W = sisr_pkg::SIG_W,
    parameter logic [W-1:0] POLY = sisr_pkg::SIG_POLY
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clear_i,
    input  logic         en_i,
    input  logic         din_i,
    input  logic         done_i,
    input  logic [W-1:0] expected_i,
    output logic [W-1:0] sig_o,
    output logic         match_o,
    output logic [W-1:0] final_o,
    output logic         pass_o
);
    typedef struct packed {
        logic [W-1:0] sig;
        logic [W-1:0] fin;
        logic         pass;
    } state_t;

    state_t       s_d, s_q;
    logic [W-1:0] shifted;
    logic         sig_eq;

    sisr_step #(.W(W), .POLY(POLY)) i_step (
        .state_i (s_q.sig),
        .bit_i   (din_i),
        .next_o  (shifted)
    );

    sisr_judge #(.W(W)) i_judge (
        .got_i   (s_q.sig),
        .want_i  (expected_i),
        .equal_o (sig_eq)
    );

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d = '0;
        end else begin
            if (done_i) begin
                s_d.fin  = s_q.sig;
                s_d.pass = sig_eq;
            end
            if (en_i) begin
                s_d.sig = shifted;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sig_o   = s_q.sig;
    assign final_o = s_q.fin;
    assign pass_o  = s_q.pass;
    assign match_o = sig_eq;

    // R1 / R2: clear empties the register next cycle, whatever else is asserted.
    assert_clear_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (sig_o == '0 && final_o == '0 && !pass_o));

    // R3: disabled capture leaves the signature untouched.
    assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && !en_i) |=> $stable(sig_o));

    // R7: done captures the pre-edge signature into the result port.
    assert_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !clear_i) |=> (final_o == $past(sig_o)));

    // R7: result stays put without done or clear.
    assert_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!done_i && !clear_i) |=> ($stable(final_o) && $stable(pass_o)));

    // R8: a nonzero state never collapses to zero on a zero input bit.
    assert_no_collapse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !clear_i && !din_i && sig_o != '0) |=> (sig_o != '0));
endmodule

// File: tb/test_sisr_compactor.sv
module test_sisr_compactor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic       en = 1'b0;
    logic       din = 1'b0;
    logic       done = 1'b0;
    logic [2:0] expected = 3'd0;
    logic [2:0] sig;
    logic       match;
    logic [2:0] fin;
    logic       pass;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [2:0] fin;
        logic       pass;
        string      req;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    sisr_compactor i_sisr_compactor (
        .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .en_i(en), .din_i(din),
        .done_i(done), .expected_i(expected), .sig_o(sig), .match_o(match),
        .final_o(fin), .pass_o(pass)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Multiply by x, add the bit, reduce modulo x^3 + x + 1.
    function automatic logic [2:0] mul_step(input logic [2:0] s, input logic d);
        logic [3:0] t;
        t = {s, d};
        if (t[3]) t = t ^ 4'b1011;
        return t[2:0];
    endfunction

    // Long division of a 7-bit stream (bit 6 shifted first) by x^3 + x + 1.
    function automatic logic [2:0] remainder7(input logic [6:0] m);
        logic [6:0] r;
        r = m;
        for (int i = 6; i >= 3; i--) begin
            if (r[i]) r = r ^ (7'b0001011 << (i - 3));
        end
        return r[2:0];
    endfunction

    // Monitor: pops an expected result after every clock that had done high.
    logic done_seen = 1'b0;
    always @(posedge clk) done_seen <= done & ~clear;
    always @(negedge clk) begin
        if (done_seen) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R7 scoreboard empty", 0, 1);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(fin == it.fin, {it.req, " final"}, fin, it.fin);
                check(pass == it.pass, {it.req, " pass"}, pass, it.pass);
            end
        end
    end

    // Inputs change 2 ns after a rising edge; outputs read at the same point.
    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic do_clear;
        clear = 1'b1;
        tick();
        clear = 1'b0;
    endtask

    // Clear, shift 7 bits with per-step checks, then done with a golden value.
    task automatic run_stream(input logic [6:0] m, input logic [2:0] gold, input string req);
        logic [2:0] model;
        do_clear();
        model = 3'd0;
        for (int i = 6; i >= 0; i--) begin
            en = 1'b1;
            din = m[i];
            tick();
            model = mul_step(model, m[i]);
            check(sig == model, "R4 step", sig, model);
        end
        en = 1'b0;
        din = 1'b0;
        check(sig == remainder7(m), "R5 remainder", sig, remainder7(m));
        expected = gold;
        #1;
        check(match == (sig == gold), "R6 match", match, sig == gold);
        sb_q.push_back('{fin: remainder7(m), pass: (remainder7(m) == gold), req: req});
        done = 1'b1;
        tick();
        done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [6:0] good;
        logic [2:0] gsig;
        logic [2:0] held;
        #12;
        check(sig == 3'd0 && fin == 3'd0 && pass == 1'b0, "R1 reset", {sig, fin, pass}, 0);
        rst_n = 1'b1;
        tick();
        check(sig == 3'd0, "R1 after reset", sig, 0);
        check(match == 1'b1, "R6 match zero", match, 1);

        good = 7'b1011001;
        gsig = remainder7(good);
        run_stream(good, gsig, "R7 good");
        run_stream(7'b0110111, 3'd0, "R7 other");
        run_stream(7'b1111111, remainder7(7'b1111111), "R7 ones");
        run_stream(7'b0000001, 3'd5, "R7 last bit");

        // R8: every single-bit flip is caught.
        for (int p = 0; p < 7; p++) begin
            logic [6:0] bad;
            bad = good ^ (7'b1 << p);
            check(remainder7(bad) != gsig, "R8 model", remainder7(bad), gsig);
            run_stream(bad, gsig, "R8 flip");
            check(sig != gsig, "R8 signature differs", sig, gsig);
        end

        // R9: aliasing stream collides with the good signature.
        run_stream(good ^ 7'b0001011, gsig, "R9 alias");
        check(sig == gsig, "R9 alias signature", sig, gsig);

        // R7: result holds while more bits shift in.
        held = fin;
        en = 1'b1;
        din = 1'b1;
        tick();
        tick();
        en = 1'b0;
        check(fin == held && pass == 1'b1, "R7 hold", fin, held);

        // R3: disabled capture ignores din.
        held = sig;
        for (int i = 0; i < 4; i++) begin
            din = i[0];
            tick();
            check(sig == held, "R3 hold", sig, held);
        end

        // R2: clear beats enable and done.
        clear = 1'b1;
        en = 1'b1;
        din = 1'b1;
        done = 1'b1;
        tick();
        clear = 1'b0;
        en = 1'b0;
        done = 1'b0;
        check(sig == 3'd0 && fin == 3'd0 && pass == 1'b0, "R2 clear priority", {sig, fin, pass}, 0);

        expected = 3'd3;
        #1;
        check(match == 1'b0, "R6 mismatch", match, 0);
        tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule